// File: doc/BRIEF.md
# Up-Counting Timer with One Software Compare Channel

This block is a free-running or modulo-wrapping up counter with one compare channel, programmed through a small word-addressed register port. A control register starts and stops counting and picks a power-of-two prescale. A modulo register sets the last count value before the counter wraps back to zero. Each wrap raises an overflow flag.

The compare channel sets an event flag on the prescaled tick at which the counter becomes equal to its compare value. Software can clear that flag from either of two places: the channel's own control word or a shared event status word. The interrupt line is high while the flag is set and the channel's interrupt enable is on. A read-only identification word tells software how wide the counter is, so the same driver can work with narrow and wide builds.

Reads are combinational from the registered state. A write takes effect at the clock edge on which it is presented.

Top module: `cmptimer`

## Requirements
- R1: After reset, every readable register except the width word (offsets 0x10, 0x14, 0x18, 0x1C, 0x20, 0x24) reads zero and `irq` is low.
- R2: Offset 0x04 reads the counter width in bits 23:16, with all other bits zero. Writes to it have no effect.
- R3: Offset 0x10 bit 3 enables counting and bits 2:0 hold a prescale select p. While enabled, the count advances by one every 2^p clock cycles. The first increment comes 2^p cycles after the enabling write. With bit 3 clear, the count holds.
- R4: On a tick where the count equals the modulo value (offset 0x18), the count becomes zero and the overflow flag (offset 0x10 bit 7) sets. Writing 1 to bit 7 clears the flag. Writing 0 to bit 7 leaves it unchanged.
- R5: Any write to the counter (offset 0x14) sets the count to zero, whatever the data.
- R6: When the mode field (offset 0x20 bits 5:2) equals 4, the channel flag (offset 0x20 bit 7) sets on the tick where the count becomes equal to the compare value (offset 0x24). Any other mode value never sets it.
- R7: Offset 0x1C bit 0 mirrors the channel flag. Writing 1 to offset 0x20 bit 7 clears the flag, and so does writing 1 to offset 0x1C bit 0.
- R8: If a clear write arrives in the same cycle as a new compare match, the flag stays set.
- R9: `irq` is high exactly while the channel flag and the interrupt enable (offset 0x20 bit 6) are both set.
- R10: Reads from unmapped offsets return zero. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | ADDR_W | Byte offset of the accessed register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Channel interrupt request |

## Verification
The bench builds the block with a 16-bit counter, so the width word reads 16. The bench can then place the modulo value anywhere in the range, from zero up to all ones. Small modulo values make wraps, repeated overflows and compare values beyond the modulo happen within a few dozen cycles. The largest prescale (divide by 128) is also exercised, and the same-cycle clear-versus-match race is placed on an exact edge.

// File: rtl/cmptimer_pkg.sv
package cmptimer_pkg;

    // register offsets (byte addresses)
    localparam logic [7:0] OFS_PARAM = 8'h04;
    localparam logic [7:0] OFS_CTRL  = 8'h10;
    localparam logic [7:0] OFS_COUNT = 8'h14;
    localparam logic [7:0] OFS_WRAP  = 8'h18;
    localparam logic [7:0] OFS_EVSTS = 8'h1C;
    localparam logic [7:0] OFS_CHCTL = 8'h20;
    localparam logic [7:0] OFS_CHCMP = 8'h24;

    localparam int DIV_SEL_W   = 3;
    localparam int WIDTH_LSB   = 16;
    localparam int BIT_OVF     = 7;
    localparam int BIT_RUN     = 3;
    localparam int BIT_CHFLAG  = 7;
    localparam int BIT_IE      = 6;
    localparam int MODE_LSB    = 2;
    localparam int BIT_EVS_CH0 = 0;
    localparam logic [3:0] MODE_SWCMP = 4'd4;

    typedef struct packed {
        logic                 run;
        logic [DIV_SEL_W-1:0] div_sel;
    } tctrl_t;

    typedef struct packed {
        logic       ie;
        logic [3:0] mode;
    } chcfg_t;

    typedef struct packed {
        logic ctrl;
        logic count;
        logic wrap;
        logic chcfg;
        logic chcmp;
        logic ovf_clr;
        logic flag_clr;
    } wstb_t;

endpackage

// File: rtl/cmptimer_prescale.sv
module cmptimer_prescale
    import cmptimer_pkg::*;
#(
    parameter int SEL_W = DIV_SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);
    localparam int PC_W = (1 << SEL_W) - 1;

    logic [PC_W-1:0] pcnt;
    logic [PC_W-1:0] limit;

    // limit = 2^sel - 1
    assign limit = {PC_W{1'b1}} >> (PC_W - int'(div_sel));
    assign tick  = run && (pcnt == limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pcnt <= '0;
        end else if (pcnt == limit) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/cmptimer_counter.sv
module cmptimer_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clr,
    input  logic             ovf_clr,
    input  logic [CNT_W-1:0] wrap,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] count_nxt,
    output logic             ovf
);
    logic wrap_hit;

    assign wrap_hit  = (count == wrap);
    assign count_nxt = wrap_hit ? '0 : count + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (tick) begin
            count <= count_nxt;
        end
    end

    // a new wrap wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) begin
            ovf <= 1'b0;
        end else if (tick && wrap_hit && !clr) begin
            ovf <= 1'b1;
        end else if (ovf_clr) begin
            ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/cmptimer_channel.sv
module cmptimer_channel
    import cmptimer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cnt_clr,
    input  logic [CNT_W-1:0] count_nxt,
    input  logic             cfg_we,
    input  chcfg_t           cfg_din,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_din,
    input  logic             flag_clr,
    output chcfg_t           cfg,
    output logic [CNT_W-1:0] cmp,
    output logic             flag,
    output logic             irq
);
    logic match;

    assign match = tick && !cnt_clr && (cfg.mode == MODE_SWCMP) && (count_nxt == cmp);
    assign irq   = flag && cfg.ie;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            cmp <= '0;
        end else begin
            if (cfg_we) cfg <= cfg_din;
            if (cmp_we) cmp <= cmp_din;
        end
    end

    // set has priority over clear
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (match) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/cmptimer_regs.sv
module cmptimer_regs
    import cmptimer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              ovf,
    input  chcfg_t            chcfg,
    input  logic [CNT_W-1:0]  chcmp,
    input  logic              flag,
    output wstb_t             stb,
    output tctrl_t            ctrl,
    output logic [CNT_W-1:0]  wrap,
    output logic [DATA_W-1:0] bus_rdata
);
    logic [ADDR_W-1:0] a_param, a_ctrl, a_count, a_wrap, a_evsts, a_chctl, a_chcmp;

    assign a_param = ADDR_W'(OFS_PARAM);
    assign a_ctrl  = ADDR_W'(OFS_CTRL);
    assign a_count = ADDR_W'(OFS_COUNT);
    assign a_wrap  = ADDR_W'(OFS_WRAP);
    assign a_evsts = ADDR_W'(OFS_EVSTS);
    assign a_chctl = ADDR_W'(OFS_CHCTL);
    assign a_chcmp = ADDR_W'(OFS_CHCMP);

    always_comb begin
        stb          = '0;
        stb.ctrl     = bus_wr && (bus_addr == a_ctrl);
        stb.count    = bus_wr && (bus_addr == a_count);
        stb.wrap     = bus_wr && (bus_addr == a_wrap);
        stb.chcfg    = bus_wr && (bus_addr == a_chctl);
        stb.chcmp    = bus_wr && (bus_addr == a_chcmp);
        stb.ovf_clr  = stb.ctrl && bus_wdata[BIT_OVF];
        stb.flag_clr = (stb.chcfg && bus_wdata[BIT_CHFLAG]) ||
                       (bus_wr && (bus_addr == a_evsts) && bus_wdata[BIT_EVS_CH0]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            wrap <= '0;
        end else begin
            if (stb.ctrl) begin
                ctrl.run     <= bus_wdata[BIT_RUN];
                ctrl.div_sel <= bus_wdata[DIV_SEL_W-1:0];
            end
            if (stb.wrap) wrap <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == a_param) begin
            bus_rdata = DATA_W'(CNT_W) << WIDTH_LSB;
        end else if (bus_addr == a_ctrl) begin
            bus_rdata[BIT_OVF]          = ovf;
            bus_rdata[BIT_RUN]          = ctrl.run;
            bus_rdata[DIV_SEL_W-1:0]    = ctrl.div_sel;
        end else if (bus_addr == a_count) begin
            bus_rdata = DATA_W'(count);
        end else if (bus_addr == a_wrap) begin
            bus_rdata = DATA_W'(wrap);
        end else if (bus_addr == a_evsts) begin
            bus_rdata[BIT_EVS_CH0] = flag;
        end else if (bus_addr == a_chctl) begin
            bus_rdata[BIT_CHFLAG]         = flag;
            bus_rdata[BIT_IE]             = chcfg.ie;
            bus_rdata[MODE_LSB+3:MODE_LSB] = chcfg.mode;
        end else if (bus_addr == a_chcmp) begin
            bus_rdata = DATA_W'(chcmp);
        end
    end
endmodule

// File: rtl/cmptimer.sv
module cmptimer
    import cmptimer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    wstb_t            stb;
    tctrl_t           ctrl;
    chcfg_t           chcfg;
    chcfg_t           chcfg_din;
    logic [CNT_W-1:0] wrap;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] count_nxt;
    logic [CNT_W-1:0] chcmp;
    logic             tick;
    logic             ovf;
    logic             ch_flag;

    assign chcfg_din.ie   = bus_wdata[BIT_IE];
    assign chcfg_din.mode = bus_wdata[MODE_LSB+3:MODE_LSB];

    cmptimer_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .count(count), .ovf(ovf), .chcfg(chcfg),
        .chcmp(chcmp), .flag(ch_flag), .stb(stb), .ctrl(ctrl), .wrap(wrap),
        .bus_rdata(bus_rdata)
    );

    cmptimer_prescale #(.SEL_W(DIV_SEL_W)) u_pre (
        .clk(clk), .rst(rst), .run(ctrl.run), .div_sel(ctrl.div_sel), .tick(tick)
    );

    cmptimer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .clr(stb.count), .ovf_clr(stb.ovf_clr),
        .wrap(wrap), .count(count), .count_nxt(count_nxt), .ovf(ovf)
    );

    cmptimer_channel #(.CNT_W(CNT_W)) u_ch0 (
        .clk(clk), .rst(rst), .tick(tick), .cnt_clr(stb.count), .count_nxt(count_nxt),
        .cfg_we(stb.chcfg), .cfg_din(chcfg_din), .cmp_we(stb.chcmp),
        .cmp_din(bus_wdata[CNT_W-1:0]), .flag_clr(stb.flag_clr),
        .cfg(chcfg), .cmp(chcmp), .flag(ch_flag), .irq(irq)
    );
endmodule

// File: rtl/cmptimer_chk.sv
module cmptimer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             count_we,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] wrap,
    input logic             ovf,
    input logic             chf,
    input logic [3:0]       mode,
    input logic             ie,
    input logic             irq
);
    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !count_we && count != wrap) |=> (count == CNT_W'($past(count) + 1'b1)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !count_we) |=> $stable(count));

    assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !count_we && count == wrap) |=> (count == '0 && ovf));

    assert_ovf_src_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf) |-> ($past(tick) && $past(count) == $past(wrap)));

    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        count_we |=> (count == '0));

    assert_match_src_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(chf) |-> ($past(tick) && $past(mode) == 4'd4));

    assert_irq_rise_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (($rose(chf) || $rose(ie)) && ie && chf));
endmodule

bind cmptimer cmptimer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .count_we(stb.count), .count(count),
    .wrap(wrap), .ovf(ovf), .chf(ch_flag), .mode(chcfg.mode), .ie(chcfg.ie),
    .irq(irq)
);

// File: tb/cmptimer_tb.sv
`timescale 1ns/1ps
module cmptimer_tb;
    localparam int CW = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    cmptimer #(.CNT_W(CW), .ADDR_W(8), .DATA_W(32)) u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // {prescale sel, modulo, compare, cycles enabled}
    localparam int NV = 9;
    localparam logic [46:0] VEC [NV] = '{
        {3'd0, 16'hFFFF, 16'd10, 12'd25},
        {3'd1, 16'hFFFF, 16'd20, 12'd30},
        {3'd3, 16'hFFFF, 16'd2,  12'd40},
        {3'd0, 16'd9,    16'd3,  12'd25},
        {3'd2, 16'd4,    16'd0,  12'd40},
        {3'd0, 16'd7,    16'd0,  12'd7},
        {3'd0, 16'd7,    16'd12, 12'd20},
        {3'd7, 16'hFFFF, 16'd1,  12'd300},
        {3'd0, 16'd0,    16'd0,  12'd5}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h10, v); chk("R1 ctrl", v, 0);
        rd(8'h14, v); chk("R1 count", v, 0);
        rd(8'h18, v); chk("R1 wrap", v, 0);
        rd(8'h1C, v); chk("R1 evsts", v, 0);
        rd(8'h20, v); chk("R1 chctl", v, 0);
        rd(8'h24, v); chk("R1 chcmp", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R2 width word, read-only
        rd(8'h04, v); chk("R2 width", v, 32'h0010_0000);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, v); chk("R2 write ignored", v, 32'h0010_0000);

        // R10 unmapped offsets
        wr(8'h18, 32'h1234);
        wr(8'h24, 32'h0055);
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h08, v); chk("R10 read 08", v, 0);
        rd(8'h00, v); chk("R10 read 00", v, 0);
        rd(8'h28, v); chk("R10 read 28", v, 0);
        rd(8'h18, v); chk("R10 wrap kept", v, 32'h1234);
        rd(8'h24, v); chk("R10 cmp kept", v, 32'h0055);
        rd(8'h10, v); chk("R10 ctrl kept", v, 0);

        // table-driven runs: R3 R4 R6 R7 R9
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  ps;
            logic [15:0] wp, cp, c;
            logic [11:0] cy;
            int          t;
            bit          eo, ef;
            {ps, wp, cp, cy} = VEC[i];
            t = int'(cy) >> ps;
            c = 0; eo = 0; ef = 0;
            for (int k = 0; k < t; k++) begin
                if (c == wp) begin c = 0; eo = 1; end
                else c = c + 1'b1;
                if (c == cp) ef = 1;
            end
            wr(8'h10, 32'h80);
            wr(8'h14, 32'h0);
            wr(8'h18, {16'b0, wp});
            wr(8'h24, {16'b0, cp});
            wr(8'h20, 32'hD0);
            wr(8'h10, 32'h8 | {29'b0, ps});
            idle(int'(cy) - 1);
            wr(8'h10, 32'h0);
            rd(8'h14, v); chk($sformatf("R3 R4 count vec%0d", i), v, {16'b0, c});
            rd(8'h10, v); chk($sformatf("R4 ovf vec%0d", i), {31'b0, v[7]}, {31'b0, eo});
            rd(8'h20, v); chk($sformatf("R6 flag vec%0d", i), v, {24'b0, ef, 7'h50});
            rd(8'h1C, v); chk($sformatf("R7 mirror vec%0d", i), v, {31'b0, ef});
            chk($sformatf("R9 irq vec%0d", i), {31'b0, irq}, {31'b0, ef});
        end

        // R4 overflow flag: write 0 keeps, write 1 clears (last vector overflowed)
        wr(8'h10, 32'h0);
        rd(8'h10, v); chk("R4 ovf kept on 0", {31'b0, v[7]}, 1);
        wr(8'h10, 32'h80);
        rd(8'h10, v); chk("R4 ovf w1c", {31'b0, v[7]}, 0);

        // R9 interrupt enable gating (flag still set from last vector)
        wr(8'h20, 32'h10);
        rd(8'h20, v); chk("R9 flag kept", {31'b0, v[7]}, 1);
        chk("R9 irq masked", {31'b0, irq}, 0);
        wr(8'h20, 32'h50);
        chk("R9 irq re-enabled", {31'b0, irq}, 1);
        // R7 clear through channel word
        wr(8'h20, 32'hD0);
        rd(8'h20, v); chk("R7 clear via 20", {31'b0, v[7]}, 0);
        chk("R9 irq low after clear", {31'b0, irq}, 0);

        // R3 hold while stopped, R5 counter write
        wr(8'h14, 32'h0);
        wr(8'h18, 32'hFFFF);
        wr(8'h10, 32'h8);
        idle(11);
        wr(8'h10, 32'h0);
        rd(8'h14, v); chk("R3 count ps0", v, 12);
        idle(10);
        rd(8'h14, v); chk("R3 stopped holds", v, 12);
        wr(8'h14, 32'hABCD);
        rd(8'h14, v); chk("R5 write zeroes", v, 0);

        // R6 other mode never sets flag
        wr(8'h24, 32'd3);
        wr(8'h20, 32'hC8);
        wr(8'h10, 32'h8);
        idle(10);
        wr(8'h10, 32'h0);
        rd(8'h20, v); chk("R6 mode 2 no flag", v, 32'h48);
        chk("R6 irq low", {31'b0, irq}, 0);

        // R8 clear in same cycle as match; R7 clear via global status
        wr(8'h14, 32'h0);
        wr(8'h24, 32'd5);
        wr(8'h20, 32'hD0);
        wr(8'h10, 32'h8);
        idle(4);
        wr(8'h1C, 32'h1);
        rd(8'h1C, v); chk("R8 set wins", v, 1);
        wr(8'h1C, 32'h1);
        rd(8'h1C, v); chk("R7 clear via 1C", v, 0);
        rd(8'h20, v); chk("R7 chctl cleared", {31'b0, v[7]}, 0);
        wr(8'h10, 32'h0);

        done = 1;
        summary();
        $finish;
    end
endmodule